// File: doc/BRIEF.md
# Debounced External Event Interrupt Controller

This block takes a bank of external event lines that can only be read, never driven. Each line is first brought into the system clock domain and then passed through a digital filter. The filter accepts a new level only after the line has held that level for a window that software sets per line, in whole milliseconds. The filtered level is compared with a per-line polarity. An enabled line that is also armed raises its status bit the first time its filtered level matches. Raising the status bit disarms the line, so a bouncing or held input produces exactly one event per arm.

A millisecond tick is made by dividing the system clock by `TICK_DIV`. All debounce counters advance only on that tick. The prescaler and the filters stop whenever no line is enabled or armed, and they restart as soon as one is. A small register port gives software access to the per-line settings, the status bits and the filtered levels. All lines drive one shared active-high level interrupt.

Top module: `eic_debounce_ctrl`

## Requirements
- R1: Register map at `addr_i` (reads are combinational on `rdata_o`):
  - 0: filtered levels, bit i = line i, read-only; writes are ignored.
  - 1: polarity.
  - 2: enable.
  - 3: arm.
  - 4: status.
  - 8+i: debounce window of line i, in ms.
- R2: A debounce write stores 1 when the value written is 0, stores 4000 when it is above 4000, and otherwise stores the value as written. Every window resets to 1.
- R3: A raw pulse shorter than `TICK_DIV` clock cycles (1 ms) never changes the filtered level, whatever window is set.
- R4: The filtered level takes a new raw value only after that value has been held without a break. The hold is more than D·`TICK_DIV` cycles and at most (D+1)·`TICK_DIV`+`SYNC_STAGES`+1 cycles, where D is the window. The level changes only on a tick. Any return to the old value restarts the count.
- R5: When a line is armed and enabled, and its filtered level equals its polarity bit (1 matches high, 0 matches low), the next edge sets its status bit and clears its arm bit. Only one status event occurs per arm.
- R6: A match on a line that is not both enabled and armed leaves its status bit unchanged.
- R7: The status bits are write-1-to-clear, and zero bits in the write have no effect. A new event in the same cycle as a clear leaves the bit set.
- R8: `irq_o` is high exactly while some line has both its status bit and its enable bit set.
- R9: `filt_run_o` is high exactly while some line is enabled or armed. While it is low, the filtered levels and the debounce progress are frozen.
- R10: After reset, registers 0 to 4 read 0, every window reads 1, and `irq_o` and `filt_run_o` are low.
- R11: Writing 1 to an arm bit arms that line, and writing 0 has no effect. The arm register reads back the lines that are still armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_LINES | Raw external event lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt, active high |
| filt_run_o | output | 1 | Filter clock enable |

## Verification
The bound checker watches several rules on every cycle:
- the filtered level moves only on a tick, and only to the value the synchronizer already presents;
- it holds still while the filter is stopped;
- every qualifying match sets status and clears the arm bit;
- no status bit rises without the line having been armed and enabled;
- the interrupt is never high while the filter is stopped.

Only the bench scenarios can show the timing of the debounce window. These are random sub-millisecond pulses that must be rejected, long holds that must land inside the window, and a one-cycle glitch that restarts the count. They also cover the clamping of window writes, one event per arm under bouncing input, and a clear that coincides with a new event.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int DB_W   = 12;
   localparam int DB_MIN = 1;
   localparam int DB_MAX = 4000;

   localparam int ADR_LEVEL   = 0;
   localparam int ADR_POL     = 1;
   localparam int ADR_EN      = 2;
   localparam int ADR_ARM     = 3;
   localparam int ADR_STAT    = 4;
   localparam int ADR_DB_BASE = 8;

   function automatic logic [DB_W-1:0] db_clamp(input logic [31:0] v);
      if (v < 32'(DB_MIN))
         return DB_W'(DB_MIN);
      else if (v > 32'(DB_MAX))
         return DB_W'(DB_MAX);
      else
         return v[DB_W-1:0];
   endfunction
endpackage

// File: rtl/eic_tick_gen.sv
module eic_tick_gen #(
   parameter int TICK_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run_i || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = run_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/eic_line_filter.sv
module eic_line_filter
   import eic_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic            raw_i,
   input  logic [DB_W-1:0] limit_i,
   output logic            sync_o,
   output logic            level_o
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic [DB_W-1:0]        cnt_q;
   logic                   level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain_q <= '0;
      else
         chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
   end

   assign sync_o = chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
      end else if (run_i) begin
         if (sync_o == level_q) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q >= limit_i) begin
               level_q <= sync_o;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign level_o = level_q;
endmodule

// File: rtl/eic_trigger.sv
module eic_trigger #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] level_i,
   input  logic [NUM_LINES-1:0] pol_i,
   input  logic [NUM_LINES-1:0] en_i,
   input  logic [NUM_LINES-1:0] arm_set_i,
   input  logic [NUM_LINES-1:0] stat_clr_i,
   output logic [NUM_LINES-1:0] arm_o,
   output logic [NUM_LINES-1:0] stat_o
);
   logic [NUM_LINES-1:0] arm_q, stat_q, fire_w;

   assign fire_w = arm_q & en_i & ~(level_i ^ pol_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= '0;
         stat_q <= '0;
      end else begin
         arm_q  <= (arm_q & ~fire_w) | arm_set_i;
         stat_q <= (stat_q & ~stat_clr_i) | fire_w;
      end
   end

   assign arm_o  = arm_q;
   assign stat_o = stat_q;
endmodule

// File: rtl/eic_debounce_ctrl.sv
module eic_debounce_ctrl
   import eic_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int TICK_DIV    = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] evt_i,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 irq_o,
   output logic                 filt_run_o
);
   localparam int ADR_SPAN = 1 << ADDR_W;

   generate
      if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
         $error("NUM_LINES must be between 1 and DATA_W");
      end
      if (DATA_W < DB_W) begin : g_bad_data
         $error("DATA_W must hold a debounce window");
      end
      if (ADR_DB_BASE + NUM_LINES > ADR_SPAN) begin : g_bad_addr
         $error("ADDR_W too small for the window registers");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic [NUM_LINES-1:0] pol_q, en_q;
   logic [NUM_LINES-1:0] level_w, sync_w, arm_w, stat_w;
   logic [NUM_LINES-1:0] arm_set_w, stat_clr_w;
   logic [DB_W-1:0]      db_arr [NUM_LINES];
   logic                 tick_w;

   wire wr_pol  = wr_en_i && (addr_i == ADDR_W'(ADR_POL));
   wire wr_en   = wr_en_i && (addr_i == ADDR_W'(ADR_EN));
   wire wr_arm  = wr_en_i && (addr_i == ADDR_W'(ADR_ARM));
   wire wr_stat = wr_en_i && (addr_i == ADDR_W'(ADR_STAT));

   assign arm_set_w  = wr_arm  ? wdata_i[NUM_LINES-1:0] : '0;
   assign stat_clr_w = wr_stat ? wdata_i[NUM_LINES-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= '0;
         en_q  <= '0;
      end else begin
         if (wr_pol) pol_q <= wdata_i[NUM_LINES-1:0];
         if (wr_en)  en_q  <= wdata_i[NUM_LINES-1:0];
      end
   end

   assign filt_run_o = |(arm_w | en_q);

   eic_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (filt_run_o),
      .tick_o (tick_w)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         logic [DB_W-1:0] db_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               db_q <= DB_W'(DB_MIN);
            else if (wr_en_i && addr_i == ADDR_W'(ADR_DB_BASE + i))
               db_q <= db_clamp(32'(wdata_i));
         end

         assign db_arr[i] = db_q;

         eic_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (filt_run_o),
            .tick_i  (tick_w),
            .raw_i   (evt_i[i]),
            .limit_i (db_q),
            .sync_o  (sync_w[i]),
            .level_o (level_w[i])
         );
      end
   endgenerate

   eic_trigger #(.NUM_LINES(NUM_LINES)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (level_w),
      .pol_i      (pol_q),
      .en_i       (en_q),
      .arm_set_i  (arm_set_w),
      .stat_clr_i (stat_clr_w),
      .arm_o      (arm_w),
      .stat_o     (stat_w)
   );

   assign irq_o = |(stat_w & en_q);

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(ADR_LEVEL)) rdata_o = DATA_W'(level_w);
      if (addr_i == ADDR_W'(ADR_POL))   rdata_o = DATA_W'(pol_q);
      if (addr_i == ADDR_W'(ADR_EN))    rdata_o = DATA_W'(en_q);
      if (addr_i == ADDR_W'(ADR_ARM))   rdata_o = DATA_W'(arm_w);
      if (addr_i == ADDR_W'(ADR_STAT))  rdata_o = DATA_W'(stat_w);
      for (int i = 0; i < NUM_LINES; i++) begin
         if (addr_i == ADDR_W'(ADR_DB_BASE + i)) rdata_o = DATA_W'(db_arr[i]);
      end
   end
endmodule

// File: rtl/eic_debounce_ctrl_chk.sv
module eic_debounce_ctrl_chk #(
   parameter int NUM_LINES = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] level_i,
   input logic [NUM_LINES-1:0] sync_i,
   input logic                 tick_i,
   input logic [NUM_LINES-1:0] pol_i,
   input logic [NUM_LINES-1:0] en_i,
   input logic [NUM_LINES-1:0] arm_i,
   input logic [NUM_LINES-1:0] arm_set_i,
   input logic [NUM_LINES-1:0] stat_i,
   input logic                 irq_i,
   input logic                 run_i
);
   logic [NUM_LINES-1:0] match_armed;
   assign match_armed = arm_i & en_i & ~(level_i ^ pol_i);

   assert_level_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i != $past(level_i)) |-> $past(tick_i));

   assert_level_follows_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((level_i ^ $past(level_i)) & (level_i ^ $past(sync_i))) == '0);

   assert_frozen_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(level_i));

   assert_fire_sets_and_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_armed != '0) |=>
         (((stat_i & $past(match_armed)) == $past(match_armed)) &&
          ((arm_i & $past(match_armed) & ~$past(arm_set_i)) == '0)));

   assert_no_unarmed_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_i & ~$past(stat_i)) & ~$past(arm_i & en_i)) == '0);

   assert_irq_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |-> run_i);
endmodule

bind eic_debounce_ctrl eic_debounce_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .level_i   (level_w),
   .sync_i    (sync_w),
   .tick_i    (tick_w),
   .pol_i     (pol_q),
   .en_i      (en_q),
   .arm_i     (arm_w),
   .arm_set_i (arm_set_w),
   .stat_i    (stat_w),
   .irq_i     (irq_o),
   .run_i     (filt_run_o)
);

// File: tb/sim_eic_debounce_ctrl.sv
module sim_eic_debounce_ctrl;
   localparam int N   = 4;
   localparam int DIV = 8;
   localparam int AW  = 5;
   localparam int DW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq, run;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [N-1:0] exp_lvl = '0;

   always #10 clk = ~clk;

   eic_debounce_ctrl #(.NUM_LINES(N), .TICK_DIV(DIV), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .filt_run_o(run)
   );

   function automatic int exp_clamp(input int v);
      if (v < 1) return 1;
      if (v > 4000) return 4000;
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      addr  = AW'(a);
      wdata = DW'(d);
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      addr = AW'(a);
      #1 v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      #(150000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      int seed;
      seed = $urandom(32'd1357);
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R10 reset state
      for (int a = 0; a < 5; a++) begin
         rd(a, v); chk("R10 reg", 32'(v), 0);
      end
      for (int i = 0; i < N; i++) begin
         rd(8 + i, v); chk("R10 window", 32'(v), 1);
      end
      chk("R10 irq", 32'(irq), 0);
      chk("R10 run", 32'(run), 0);

      // R2 clamping of window writes
      wr(8, 0);      rd(8, v);  chk("R2 zero", 32'(v), 32'(exp_clamp(0)));
      wr(9, 5000);   rd(9, v);  chk("R2 above", 32'(v), 32'(exp_clamp(5000)));
      wr(10, 4000);  rd(10, v); chk("R2 max", 32'(v), 32'(exp_clamp(4000)));
      wr(11, 3);     rd(11, v); chk("R2 mid", 32'(v), 32'(exp_clamp(3)));
      wr(9, 1); wr(10, 1); wr(11, 1);

      // R9 frozen while nothing enabled or armed
      evt = 4'b0001;
      idle(8 * DIV);
      rd(0, v); chk("R9 frozen level", 32'(v), 0);
      chk("R9 run low", 32'(run), 0);
      wr(2, 4'hF);
      chk("R9 run high", 32'(run), 1);
      idle(2 * DIV + 6);
      exp_lvl = 4'b0001;
      rd(0, v); chk("R9 resumed level", 32'(v), 32'(exp_lvl));

      // R1 level register is read-only
      wr(0, 16'hFFFF);
      rd(0, v); chk("R1 level write ignored", 32'(v), 32'(exp_lvl));

      // R6 match while enabled but not armed
      idle(4);
      rd(4, v); chk("R6 no status unarmed", 32'(v), 0);
      chk("R6 irq", 32'(irq), 0);

      // R4 directed restart: window 2 on line 3
      wr(11, 2);
      evt[3] = ~exp_lvl[3];
      idle(2 * DIV - 2);
      evt[3] = exp_lvl[3];
      idle(1);
      evt[3] = ~exp_lvl[3];
      idle(2 * DIV);
      rd(0, v); chk("R4 restart holds", 32'(v[3]), 32'(exp_lvl[3]));
      idle(DIV + 6);
      exp_lvl[3] = ~exp_lvl[3];
      rd(0, v); chk("R4 after restart", 32'(v[3]), 32'(exp_lvl[3]));

      // R3 and R4 random pulses
      for (int it = 0; it < 40; it++) begin
         int ln;
         int db;
         int lng;
         int len;
         ln  = $urandom_range(N - 1, 0);
         db  = $urandom_range(3, 1);
         lng = $urandom_range(1, 0);
         wr(8 + ln, db);
         if (lng != 0) begin
            len = (db + 1) * DIV + 6 + $urandom_range(4, 0);
            evt[ln] = ~exp_lvl[ln];
            idle(db * DIV);
            rd(0, v); chk("R4 not early", 32'(v[ln]), 32'(exp_lvl[ln]));
            idle(DIV + 4);
            exp_lvl[ln] = ~exp_lvl[ln];
            rd(0, v); chk("R4 in window", 32'(v[ln]), 32'(exp_lvl[ln]));
            idle(len - (db + 1) * DIV - 4);
         end else begin
            len = $urandom_range(DIV - 1, 1);
            evt[ln] = ~exp_lvl[ln];
            idle(len);
            evt[ln] = exp_lvl[ln];
            idle((db + 2) * DIV);
            rd(0, v); chk("R3 short rejected", 32'(v[ln]), 32'(exp_lvl[ln]));
         end
      end

      // R11 arm register
      wr(3, 0);
      rd(3, v); chk("R11 zero write", 32'(v), 0);

      // R5 single trigger on line 2, high polarity
      wr(10, 1);
      if (exp_lvl[2]) begin
         evt[2] = 1'b0;
         idle(3 * DIV);
         exp_lvl[2] = 1'b0;
      end
      wr(1, 4'b0100);
      wr(3, 4'b0100);
      idle(2);
      rd(3, v); chk("R11 armed", 32'(v), 32'h4);
      rd(4, v); chk("R5 no match yet", 32'(v), 0);
      evt[2] = 1'b1;
      idle(2 * DIV + 6);
      exp_lvl[2] = 1'b1;
      rd(4, v); chk("R5 status set", 32'(v), 32'h4);
      rd(3, v); chk("R5 disarmed", 32'(v), 0);
      chk("R8 irq on", 32'(irq), 1);
      evt[2] = 1'b0; idle(3 * DIV);
      evt[2] = 1'b1; idle(3 * DIV);
      wr(4, 0);
      rd(4, v); chk("R7 zero clear", 32'(v), 32'h4);
      wr(4, 4'b0100);
      rd(4, v); chk("R7 cleared", 32'(v), 0);
      chk("R8 irq off", 32'(irq), 0);
      idle(10);
      rd(4, v); chk("R5 one per arm", 32'(v), 0);

      // R7 event in same cycle as clear
      wr(3, 4'b0100);
      wr(4, 4'b0100);
      rd(4, v); chk("R7 set wins", 32'(v), 32'h4);
      rd(3, v); chk("R5 disarm again", 32'(v), 0);

      // R8 enable gates the interrupt
      wr(2, 4'b1011);
      chk("R8 masked", 32'(irq), 0);
      rd(4, v); chk("R8 status kept", 32'(v), 32'h4);
      wr(2, 4'hF);
      chk("R8 unmasked", 32'(irq), 1);
      wr(4, 4'hF);
      chk("R8 cleared", 32'(irq), 0);

      // R9 stop and restart by arming
      wr(2, 0);
      chk("R9 stopped", 32'(run), 0);
      evt = ~exp_lvl;
      idle(5 * DIV);
      rd(0, v); chk("R9 frozen again", 32'(v), 32'(exp_lvl));
      wr(3, 4'b0001);
      chk("R9 arm restarts", 32'(run), 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule